// File: doc/BRIEF.md
# Locked Read-Modify-Write Bus Sequencer

This block sits between a core's execute stage and a simple memory bus. It carries out plain loads and stores, and three read-modify-write operations: compare-and-swap, swap-with-memory and fetch-and-add. A read-modify-write operation that is locked first waits until the core's store buffer reports empty, which makes it a full barrier. It then raises a bus lock, reads the destination, writes the destination, and drops the lock only after the last write has been accepted.

Operands are 1, 2, 4 or 8 bytes wide and may sit at any byte address. An operand that runs past the end of a cache line is split into two bus accesses. The first access covers the bytes up to the line end, and the second starts at the next line. A locked operand split this way takes four bus cycles, and the lock is held over all four. A compare-and-swap always writes. When the compare fails, the value it read goes back unchanged.

Top module: `atomic_rmw_seq`

## Requirements
- R1: Compare-and-swap (op code 3) reads the operand and then always writes it. It writes the source when the read value equals the compare value (both masked to the operand size), and writes the read value back otherwise. It returns the read value, with rsp_zf set only on a match.
- R2: Swap (op code 2) is locked even when req_lock is 0. It writes the source and returns the old value.
- R3: Fetch-and-add (op code 4) returns the old value and writes old plus source, truncated to the operand size.
- R4: A locked operation issues no bus access until sb_empty has been seen high while the block is waiting. Plain operations and unlocked read-modify-write operations do not wait.
- R5: bus_lock rises in the cycle the first locked read is presented. It stays high through every following read and write of the sequence, and falls in the cycle after the final write is accepted. No locked read is left without a locked write after it.
- R6: No bus access crosses a LINE_BYTES boundary. An operand whose offset within the line plus its size exceeds LINE_BYTES is split. The first access is at the request address with length LINE_BYTES minus the offset. The second is at the request address plus that length, with the remaining bytes.
- R7: Load (op code 0) and store (op code 1) are unlocked. They make one access when the operand fits in the line and two unlocked accesses when it crosses the line. A load returns the bytes read, and a store returns zero.
- R8: While bus_valid is high and bus_ready is low, bus_addr, bus_we, bus_len and bus_wdata stay unchanged in the next cycle.
- R9: req_ready is high only in the idle state, so one request is accepted per sequence. rsp_valid is a one-cycle pulse in the cycle after the final bus access is accepted.
- R10: During and right after reset, req_ready is 1 and bus_valid, bus_lock and rsp_valid are 0.
- R11: Operand size codes 0 to 3 mean 1, 2, 4 and 8 bytes. Bus data is little-endian in the low bus_len bytes. Write bytes above bus_len are zero, and read bytes above bus_len are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken |
| req_op | input | 3 | 0 load, 1 store, 2 swap, 3 compare-and-swap, 4 fetch-and-add |
| req_lock | input | 1 | Lock the read-modify-write |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Size code (bytes = 1 << code) |
| req_src | input | 64 | Store, swap, new or addend value |
| req_cmp | input | 64 | Compare value |
| rsp_valid | output | 1 | Result pulse |
| rsp_data | output | 64 | Old memory value (zero for store) |
| rsp_zf | output | 1 | Compare matched |
| sb_empty | input | 1 | Store buffer drained |
| bus_valid | output | 1 | Bus access presented |
| bus_ready | input | 1 | Bus access accepted |
| bus_we | output | 1 | Write access |
| bus_lock | output | 1 | Bus lock |
| bus_addr | output | ADDR_W | Access byte address |
| bus_len | output | 4 | Access length in bytes |
| bus_wdata | output | 64 | Write data |
| bus_rdata | input | 64 | Read data, valid with bus_ready |

## Verification
A wrong sequencer state shows up on the bus in the very cycle it takes effect. Examples are an access that is missing or extra, a wrong split length or address, a write-back skipped on a failed compare, or a lock that drops between the read and the write. A corrupted assembled old value shows up either as the wrong write data of that same sequence or as the wrong rsp_data one cycle after the final acceptance. A barrier violation appears as bus_valid high while sb_empty is still low, which is visible within one cycle of the request.

// File: rtl/atomic_rmw_seq.sv
`timescale 1ns/1ps
module atomic_rmw_seq #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic              req_lock,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [63:0]       req_src,
  input  logic [63:0]       req_cmp,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              rsp_zf,
  input  logic              sb_empty,
  output logic              bus_valid,
  input  logic              bus_ready,
  output logic              bus_we,
  output logic              bus_lock,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [3:0]        bus_len,
  output logic [63:0]       bus_wdata,
  input  logic [63:0]       bus_rdata
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam logic [2:0] OP_LOAD = 3'd0, OP_STORE = 3'd1, OP_XCHG = 3'd2,
                         OP_CAS = 3'd3, OP_FADD = 3'd4;

  typedef enum logic [2:0] {S_IDLE, S_DRAIN, S_RD0, S_RD1, S_WR0, S_WR1, S_RESP} st_t;

  function automatic logic [63:0] bmask(input logic [3:0] n);
    return (n == 4'd0) ? 64'd0 : ({64{1'b1}} >> (7'd64 - {n, 3'b000}));
  endfunction

  st_t               st;
  logic [2:0]        op_q;
  logic              split_q, lock_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        nb_q, len0_q;
  logic [63:0]       src_q, cmp_q, old_q, new_val;

  wire [3:0]     req_nb    = 4'd1 << req_size;
  wire [OFF_W:0] room      = (OFF_W+1)'(LINE_BYTES) - {1'b0, req_addr[OFF_W-1:0]};
  wire           req_cross = 32'(req_nb) > 32'(room);
  wire [3:0]     req_len0  = req_cross ? room[3:0] : req_nb;
  wire           req_rmw   = req_op inside {OP_XCHG, OP_CAS, OP_FADD};
  wire           req_lk    = req_rmw && (req_lock || req_op == OP_XCHG);

  wire [3:0]  len1   = nb_q - len0_q;
  wire [63:0] m_all  = bmask(nb_q);
  wire        cas_eq = ((old_q ^ cmp_q) & m_all) == 64'd0;
  wire        is_rmw = op_q inside {OP_XCHG, OP_CAS, OP_FADD};
  wire        second = st inside {S_RD1, S_WR1};
  wire        acc    = bus_valid && bus_ready;

  always_comb begin
    case (op_q)
      OP_STORE, OP_XCHG: new_val = src_q & m_all;
      OP_CAS:            new_val = cas_eq ? (src_q & m_all) : old_q;
      OP_FADD:           new_val = (old_q + src_q) & m_all;
      default:           new_val = old_q;
    endcase
  end

  assign req_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_data  = old_q;
  assign rsp_zf    = rsp_valid && op_q == OP_CAS && cas_eq;
  assign bus_valid = st inside {S_RD0, S_RD1, S_WR0, S_WR1};
  assign bus_we    = st inside {S_WR0, S_WR1};
  assign bus_lock  = lock_q;
  assign bus_addr  = second ? addr_q + ADDR_W'(len0_q) : addr_q;
  assign bus_len   = second ? len1 : len0_q;
  assign bus_wdata = !bus_we ? 64'd0 :
                     second  ? ((new_val >> {len0_q, 3'b000}) & bmask(len1)) :
                               (new_val & bmask(len0_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op_q <= OP_LOAD; split_q <= 1'b0; lock_q <= 1'b0;
      addr_q <= '0; nb_q <= 4'd1; len0_q <= 4'd1;
      src_q <= '0; cmp_q <= '0; old_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          op_q <= req_op; addr_q <= req_addr; nb_q <= req_nb; len0_q <= req_len0;
          split_q <= req_cross; src_q <= req_src; cmp_q <= req_cmp; old_q <= '0;
          st <= req_lk ? S_DRAIN : (req_op == OP_STORE ? S_WR0 : S_RD0);
        end
        S_DRAIN: if (sb_empty) begin
          lock_q <= 1'b1;
          st <= S_RD0;
        end
        S_RD0: if (acc) begin
          old_q <= bus_rdata & bmask(len0_q);
          st <= split_q ? S_RD1 : (is_rmw ? S_WR0 : S_RESP);
        end
        S_RD1: if (acc) begin
          old_q <= old_q | ((bus_rdata & bmask(len1)) << {len0_q, 3'b000});
          st <= is_rmw ? S_WR0 : S_RESP;
        end
        S_WR0: if (acc) begin
          if (split_q) st <= S_WR1;
          else begin st <= S_RESP; lock_q <= 1'b0; end
        end
        S_WR1: if (acc) begin
          st <= S_RESP; lock_q <= 1'b0;
        end
        S_RESP:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R8
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_we)
                               && $stable(bus_len) && $stable(bus_wdata));
  // R6
  no_cross_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (32'(bus_addr[OFF_W-1:0]) + 32'(bus_len) <= LINE_BYTES));
  // R4
  drain_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_lock) |-> $past(sb_empty));
  // R5
  unlock_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_lock) |-> $past(bus_valid && bus_ready && bus_we));
  // R5
  locked_read_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_lock && bus_valid && bus_ready && !bus_we |=> bus_valid && bus_lock);
  // R9
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
endmodule

// File: tb/tb_atomic_rmw_seq.sv
`timescale 1ns/1ps
module tb_atomic_rmw_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_lock = 1'b0, sb_empty = 1'b1, bus_ready = 1'b0;
  logic [2:0] req_op = '0;
  logic [31:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [63:0] req_src = '0, req_cmp = '0, bus_rdata = '0;
  logic req_ready, rsp_valid, rsp_zf, bus_valid, bus_we, bus_lock;
  logic [63:0] rsp_data, bus_wdata;
  logic [31:0] bus_addr;
  logic [3:0] bus_len;

  atomic_rmw_seq dut (.*);

  always #2.5 clk = ~clk;

  logic [7:0] mem [256];
  logic [7:0] lfsr = 8'h5D;
  int checks = 0, fails = 0;
  logic [31:0] q_addr[$];
  bit          q_we[$];
  int          q_len[$];
  logic [63:0] q_wd[$];
  bit          q_lk[$];

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  function automatic logic [63:0] msk(input int n);
    return (n >= 8) ? '1 : ((64'd1 << (8*n)) - 64'd1);
  endfunction

  task automatic push(input logic [31:0] a, input bit we, input int len, input logic [63:0] wd, input bit lk);
    q_addr.push_back(a); q_we.push_back(we); q_len.push_back(len); q_wd.push_back(wd); q_lk.push_back(lk);
  endtask

  task automatic run(input logic [2:0] op, input bit lk, input logic [31:0] a, input logic [1:0] sz,
                     input logic [63:0] src, input logic [63:0] cmp, input int sbw, input string r);
    int n = 1 << sz;
    int off = int'(a % 64);
    int l0 = (off + n > 64) ? 64 - off : n;
    int l1 = n - l0;
    bit rmw = (op >= 3'd2 && op <= 3'd4);
    bit lkd = rmw && (lk || op == 3'd2);
    logic [63:0] m = msk(n), old = '0, nv = '0, exp_data;
    bit exp_zf, done = 0, resp_due = 0;
    int drain = sbw, guard = 0;
    if (op != 3'd1)
      for (int i = 0; i < n; i++) old |= 64'(mem[(int'(a) + i) % 256]) << (8*i);
    case (op)
      3'd1, 3'd2: nv = src & m;
      3'd3:       nv = (old == (cmp & m)) ? (src & m) : old;
      3'd4:       nv = (old + src) & m;
      default:    nv = '0;
    endcase
    exp_zf = (op == 3'd3) && (old == (cmp & m));
    exp_data = (op == 3'd1) ? 64'd0 : old;
    if (op != 3'd1) begin
      push(a, 0, l0, 0, lkd);
      if (l1 > 0) push(a + l0, 0, l1, 0, lkd);
    end
    if (op == 3'd1 || rmw) begin
      push(a, 1, l0, nv & msk(l0), lkd);
      if (l1 > 0) push(a + l0, 1, l1, (nv >> (8*l0)) & msk(l1), lkd);
    end
    @(negedge clk);
    chk(req_ready == 1'b1, {r, " R9 idle ready"}, 64'(req_ready), 1);
    req_valid = 1; req_op = op; req_lock = lk; req_addr = a; req_size = sz;
    req_src = src; req_cmp = cmp; sb_empty = (sbw == 0);
    @(negedge clk);
    req_valid = 0;
    chk(req_ready == 1'b0, {r, " R9 busy"}, 64'(req_ready), 0);
    while (!done) begin
      if (resp_due) begin
        chk(rsp_valid == 1'b1, {r, " R9 rsp pulse"}, 64'(rsp_valid), 1);
        chk(rsp_data == exp_data, {r, " rsp_data"}, rsp_data, exp_data);
        chk(rsp_zf == exp_zf, {r, " R1 zf"}, 64'(rsp_zf), 64'(exp_zf));
        chk(bus_lock == 1'b0, {r, " R5 lock drop"}, 64'(bus_lock), 0);
        bus_ready = 0;
        done = 1;
      end else begin
        chk(rsp_valid == 1'b0, {r, " R9 no early rsp"}, 64'(rsp_valid), 0);
        if (lkd && drain > 0) chk(bus_valid == 1'b0, {r, " R4 barrier"}, 64'(bus_valid), 0);
        if (drain > 0) begin drain--; if (drain == 0) sb_empty = 1; end
        if (bus_valid) begin
          if (q_addr.size() == 0) begin
            chk(0, {r, " R5 extra access"}, 64'(bus_addr), 0);
            bus_ready = 1;
          end else begin
            chk(bus_addr == q_addr[0], {r, " R6 addr"}, 64'(bus_addr), 64'(q_addr[0]));
            chk(bus_we == q_we[0], {r, " R1 access kind"}, 64'(bus_we), 64'(q_we[0]));
            chk(int'(bus_len) == q_len[0], {r, " R6 len"}, 64'(bus_len), 64'(q_len[0]));
            chk(bus_lock == q_lk[0], {r, " R5 lock"}, 64'(bus_lock), 64'(q_lk[0]));
            if (bus_we) chk(bus_wdata == q_wd[0], {r, " R11 wdata"}, bus_wdata, q_wd[0]);
            bus_ready = lfsr[0] | lfsr[1];
            if (bus_ready) begin
              if (!bus_we) begin
                bus_rdata = {8{8'hA5}};
                for (int i = 0; i < int'(bus_len); i++) bus_rdata[8*i +: 8] = mem[(int'(bus_addr) + i) % 256];
              end else
                for (int i = 0; i < int'(bus_len); i++) mem[(int'(bus_addr) + i) % 256] = bus_wdata[8*i +: 8];
              void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_len.pop_front());
              void'(q_wd.pop_front()); void'(q_lk.pop_front());
              if (q_addr.size() == 0) resp_due = 1;
            end
          end
        end else begin
          chk(bus_lock == 1'b0, {r, " R5 idle lock"}, 64'(bus_lock), 0);
          bus_ready = 0;
        end
      end
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      guard++;
      if (guard > 400) begin chk(0, {r, " R9 stalled"}, 0, 1); done = 1; end
      if (!done) @(negedge clk);
    end
    if (q_addr.size() != 0) begin
      chk(0, {r, " R5 missing access"}, 64'(q_addr.size()), 0);
      q_addr.delete(); q_we.delete(); q_len.delete(); q_wd.delete(); q_lk.delete();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    repeat (2) @(negedge clk);
    chk(req_ready == 1'b1 && bus_valid == 1'b0 && bus_lock == 1'b0 && rsp_valid == 1'b0,
        "R10 reset", {60'd0, req_ready, bus_valid, bus_lock, rsp_valid}, 64'h8);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1'b1 && bus_valid == 1'b0, "R10 after reset", 64'(bus_valid), 0);
    run(3'd1, 0, 32'h10, 2'd3, 64'h1122334455667788, 0, 0, "R7 store8");
    run(3'd0, 0, 32'h10, 2'd2, 0, 0, 0, "R7 load4");
    run(3'd3, 1, 32'h10, 2'd3, 64'hCAFEF00DDEADBEEF, 64'h1122334455667788, 3, "R1 cas hit");
    run(3'd3, 1, 32'h10, 2'd3, 64'h0, 64'h1234, 2, "R1 cas miss");
    run(3'd0, 0, 32'h10, 2'd3, 0, 0, 0, "R1 readback");
    run(3'd2, 0, 32'h20, 2'd2, 64'hFFFF_0000_A1B2C3D4, 0, 4, "R2 swap");
    run(3'd1, 0, 32'h30, 2'd1, 64'h0000_FFFF, 0, 0, "R7 store2");
    run(3'd4, 1, 32'h30, 2'd1, 64'h2, 0, 1, "R3 fadd wrap");
    run(3'd0, 0, 32'h30, 2'd1, 0, 0, 0, "R3 readback");
    run(3'd3, 1, 32'h3C, 2'd3, 64'h0102030405060708, 64'h0, 2, "R6 cas split miss");
    run(3'd0, 0, 32'h3C, 2'd3, 0, 0, 0, "R6 load split");
    run(3'd3, 1, 32'h3C, 2'd3, 64'h0102030405060708, 64'h4746454443423F3E & 64'h0, 0, "R6 cas split");
    run(3'd1, 0, 32'h7E, 2'd2, 64'h99887766, 0, 3, "R7 store split no wait");
    run(3'd0, 0, 32'h7E, 2'd2, 0, 0, 5, "R7 load split no wait");
    run(3'd3, 0, 32'h50, 2'd2, 64'h55, 64'h0, 3, "R4 unlocked cas");
    run(3'd4, 1, 32'hBF, 2'd1, 64'h0101, 0, 2, "R6 fadd split");
    run(3'd0, 0, 32'hBF, 2'd1, 0, 0, 0, "R3 split readback");
    run(3'd2, 1, 32'hF9, 2'd3, 64'hDEADBEEF00C0FFEE, 0, 0, "R2 swap split");
    run(3'd0, 0, 32'hF9, 2'd0, 0, 0, 0, "R11 load1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule